// File: doc/BRIEF.md
# Scatter-Gather Receive Engine (Stream to Memory)

This block is the receive half of a descriptor-driven DMA. A chain of descriptors sits in word-addressed memory. Each descriptor is nine 32-bit words: offset 0 holds the pointer to the next descriptor, offset 1 the buffer base address, offset 2 a control word whose bits [22:0] give the buffer capacity in data beats, offset 3 a status word the engine writes back, and offsets 4 to 8 five application words. The memory port has separate read and write strobes and returns read data one cycle after a read strobe.

Packet beats arrive on an AXI4-Stream data slave and are written one word per beat into the current descriptor's buffer. When a buffer fills, the rest of the packet continues in the next descriptor. A second AXI4-Stream slave carries five application words per packet. These words are latched and copied only into the descriptor that holds the end of the packet.

Software-side control uses a level `run`, writes to the current pointer and the tail pointer, and `halted` and `idle` flags. The engine stops and goes idle after it finishes the tail descriptor. Writing a new tail pointer resumes it.

Top module: `sg_s2mm_rx`

## Requirements
- R1: After reset `halted` is 1, `idle` is 0, `cur_ptr` is 0, and `s_tready` and `pkt_done` are 0.
- R2: `s_tready` is 1 only while `run` is 1, `halted` is 0 and `idle` is 0. When `run` is 0, `halted` is 1 from the next cycle. A rising edge of `run` clears `halted` and `idle`.
- R3: A descriptor stores at most its capacity (control bits [22:0], in beats) at consecutive words from its buffer address. Any remaining beats of the packet go to the next descriptor's buffer.
- R4: If a fetched descriptor's status bit 31 is already 1, `halted` becomes 1. No beat is accepted and nothing is written to that descriptor.
- R5: Every written-back status word has bit 31 set. Its bits [22:0] hold the number of beats stored in that descriptor.
- R6: Status bit 27 is 1 when the descriptor holds the first beat of a packet. It is true for the first descriptor after reset, and afterwards it equals whether the previous descriptor ended a packet.
- R7: The descriptor holding the last beat of a packet gets status bit 26 set and the latched application words at offsets 4..8, and `pkt_done` pulses for one cycle. Other descriptors keep their application words unchanged.
- R8: After write-back, `cur_ptr` takes the descriptor's next pointer. If the finished descriptor was the tail, `idle` becomes 1. A tail pointer write clears `idle`.
- R9: A control packet of exactly five words, ending with `c_tlast`, replaces the latched application words. A control packet of any other length pulses `ctl_err` and leaves the latched words unchanged.
- R10: If no new control packet arrives before a packet ends, the previously latched application words are written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable level |
| cur_we | input | 1 | Load strobe for the current descriptor pointer |
| cur_wdata | input | AW | New current pointer |
| tail_we | input | 1 | Load strobe for the tail pointer; clears idle |
| tail_wdata | input | AW | New tail pointer |
| cur_ptr | output | AW | Current descriptor pointer |
| halted | output | 1 | Channel halted |
| idle | output | 1 | Tail descriptor finished |
| s_tvalid | input | 1 | Data stream valid |
| s_tready | output | 1 | Data stream ready |
| s_tdata | input | DW | Data stream word |
| s_tlast | input | 1 | Last beat of packet |
| c_tvalid | input | 1 | Control stream valid |
| c_tready | output | 1 | Control stream ready (always 1) |
| c_tdata | input | DW | Application word |
| c_tlast | input | 1 | Last application word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, one cycle after mem_rd |
| pkt_done | output | 1 | One-cycle pulse on packet completion |
| ctl_err | output | 1 | One-cycle pulse on a control packet of wrong length |

## Verification
A wrong start-of-frame flag or beat counter shows up in the very next status word written back: the count and the bit 27/26 flags are off by the time the descriptor completes. A stale or skipped pointer shows as data landing in the wrong buffer and as `cur_ptr` or `idle` being wrong right after the tail descriptor. A fault in the application latch shows only on the next end-of-packet write-back, so each test packet is checked after its own control packet, and also after a missing or malformed one.

// File: rtl/sg_rx_pkg.sv
package sg_rx_pkg;
   localparam int STS_DONE_BIT = 31;
   localparam int STS_SOF_BIT  = 27;
   localparam int STS_EOF_BIT  = 26;
   localparam int OFS_STS      = 3;
   localparam int OFS_APP      = 4;
   localparam int HDR_WORDS    = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_CAP, ST_RECV, ST_WSTS, ST_WAPP, ST_ADV
   } rx_state_e;
endpackage

// File: rtl/sg_rx_app_latch.sv
module sg_rx_app_latch #(
   parameter int DW        = 32,
   parameter int APP_WORDS = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    c_tvalid,
   input  logic [DW-1:0]           c_tdata,
   input  logic                    c_tlast,
   output logic [APP_WORDS*DW-1:0] app_flat,
   output logic                    err_o
);
   localparam int CW = $clog2(APP_WORDS + 2);

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] shadow_q [APP_WORDS];
   logic          good_end;

   if (APP_WORDS < 1) begin : g_bad_words
      $error("APP_WORDS must be at least 1");
   end

   assign good_end = c_tvalid && c_tlast && (cnt_q == CW'(APP_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_o <= 1'b0;
      end else begin
         err_o <= c_tvalid && c_tlast && !good_end;
         if (c_tvalid) begin
            if (c_tlast) cnt_q <= '0;
            else if (cnt_q <= CW'(APP_WORDS)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < APP_WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q[i]             <= '0;
            app_flat[i*DW +: DW]    <= '0;
         end else begin
            if (c_tvalid && cnt_q == CW'(i)) shadow_q[i] <= c_tdata;
            if (good_end)
               app_flat[i*DW +: DW] <= (i == APP_WORDS - 1) ? c_tdata : shadow_q[i];
         end
      end
   end

   // R9
   bad_len_keeps_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $stable(app_flat));
endmodule

// File: rtl/sg_rx_chan_regs.sv
module sg_rx_chan_regs #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          cur_we,
   input  logic [AW-1:0] cur_wdata,
   input  logic          tail_we,
   input  logic [AW-1:0] tail_wdata,
   input  logic          adv_i,
   input  logic [AW-1:0] next_i,
   input  logic          halt_set_i,
   output logic [AW-1:0] cur_ptr,
   output logic          halted,
   output logic          idle,
   output logic          active
);
   logic [AW-1:0] tail_q;
   logic          run_q;

   if (AW < 4) begin : g_bad_aw
      $error("AW too small for descriptor addressing");
   end

   assign active = run && !halted && !idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_ptr <= '0;
         tail_q  <= '0;
         halted  <= 1'b1;
         idle    <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         run_q <= run;
         if (adv_i) begin
            cur_ptr <= next_i;
            if (cur_ptr == tail_q) idle <= 1'b1;
         end
         if (cur_we) cur_ptr <= cur_wdata;
         if (tail_we) begin
            tail_q <= tail_wdata;
            idle   <= 1'b0;
         end
         if (run && !run_q) begin
            halted <= 1'b0;
            idle   <= 1'b0;
         end
         if (halt_set_i || !run) halted <= 1'b1;
      end
   end

   // R2
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> halted);
   // R8
   idle_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> $past(adv_i));
endmodule

// File: rtl/sg_s2mm_rx.sv
module sg_s2mm_rx
   import sg_rx_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int LEN_W     = 23,
   parameter int APP_WORDS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          cur_we,
   input  logic [AW-1:0] cur_wdata,
   input  logic          tail_we,
   input  logic [AW-1:0] tail_wdata,
   output logic [AW-1:0] cur_ptr,
   output logic          halted,
   output logic          idle,
   input  logic          s_tvalid,
   output logic          s_tready,
   input  logic [DW-1:0] s_tdata,
   input  logic          s_tlast,
   input  logic          c_tvalid,
   output logic          c_tready,
   input  logic [DW-1:0] c_tdata,
   input  logic          c_tlast,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          pkt_done,
   output logic          ctl_err
);
   localparam int AIW = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;

   if (DW < 32) begin : g_bad_dw
      $error("DW must hold a 32-bit status word");
   end
   if (LEN_W > STS_EOF_BIT) begin : g_bad_len
      $error("LEN_W overlaps status flags");
   end

   rx_state_e              state_q;
   logic [1:0]             fidx_q;
   logic [AIW-1:0]         aidx_q;
   logic [AW-1:0]          nxt_q, buf_q;
   logic [LEN_W-1:0]       cap_q, cnt_q;
   logic                   sof_q, eof_q;
   logic                   active, adv, halt_set, beat;
   logic [APP_WORDS*DW-1:0] app_flat;
   logic [DW-1:0]          sts_word;

   sg_rx_chan_regs #(.AW(AW)) u_regs (
      .clk, .rst_n, .run, .cur_we, .cur_wdata, .tail_we, .tail_wdata,
      .adv_i(adv), .next_i(nxt_q), .halt_set_i(halt_set),
      .cur_ptr, .halted, .idle, .active
   );

   sg_rx_app_latch #(.DW(DW), .APP_WORDS(APP_WORDS)) u_app (
      .clk, .rst_n, .c_tvalid, .c_tdata, .c_tlast,
      .app_flat, .err_o(ctl_err)
   );

   assign c_tready = 1'b1;
   assign s_tready = (state_q == ST_RECV) && active && (cap_q != '0);
   assign beat     = s_tvalid && s_tready;
   assign pkt_done = (state_q == ST_WSTS) && eof_q;

   always_comb begin
      sts_word               = '0;
      sts_word[STS_DONE_BIT] = 1'b1;
      sts_word[STS_SOF_BIT]  = sof_q;
      sts_word[STS_EOF_BIT]  = eof_q;
      sts_word[LEN_W-1:0]    = cnt_q;
   end

   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      adv       = 1'b0;
      halt_set  = 1'b0;
      unique case (state_q)
         ST_RD: begin
            mem_rd   = 1'b1;
            mem_addr = cur_ptr + AW'(fidx_q);
         end
         ST_CAP: halt_set = (fidx_q == 2'd3) && mem_rdata[STS_DONE_BIT];
         ST_RECV: begin
            mem_wr    = beat;
            mem_addr  = buf_q + AW'(cnt_q);
            mem_wdata = s_tdata;
         end
         ST_WSTS: begin
            mem_wr    = 1'b1;
            mem_addr  = cur_ptr + AW'(OFS_STS);
            mem_wdata = sts_word;
         end
         ST_WAPP: begin
            mem_wr    = 1'b1;
            mem_addr  = cur_ptr + AW'(OFS_APP) + AW'(aidx_q);
            mem_wdata = app_flat[aidx_q*DW +: DW];
         end
         ST_ADV: adv = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fidx_q  <= '0;
         aidx_q  <= '0;
         nxt_q   <= '0;
         buf_q   <= '0;
         cap_q   <= '0;
         cnt_q   <= '0;
         sof_q   <= 1'b1;
         eof_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (active) begin
               fidx_q  <= '0;
               state_q <= ST_RD;
            end
            ST_RD: state_q <= ST_CAP;
            ST_CAP: begin
               unique case (fidx_q)
                  2'd0: nxt_q <= mem_rdata[AW-1:0];
                  2'd1: buf_q <= mem_rdata[AW-1:0];
                  2'd2: cap_q <= mem_rdata[LEN_W-1:0];
                  default: ;
               endcase
               if (fidx_q == 2'(HDR_WORDS - 1)) begin
                  cnt_q   <= '0;
                  eof_q   <= 1'b0;
                  state_q <= mem_rdata[STS_DONE_BIT] ? ST_IDLE : ST_RECV;
               end else begin
                  fidx_q  <= fidx_q + 1'b1;
                  state_q <= ST_RD;
               end
            end
            ST_RECV: begin
               if (cap_q == '0) state_q <= ST_WSTS;
               else if (beat) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (s_tlast) begin
                     eof_q   <= 1'b1;
                     state_q <= ST_WSTS;
                  end else if (cnt_q + 1'b1 == cap_q) begin
                     state_q <= ST_WSTS;
                  end
               end
            end
            ST_WSTS: begin
               aidx_q  <= '0;
               state_q <= eof_q ? ST_WAPP : ST_ADV;
            end
            ST_WAPP: begin
               aidx_q <= aidx_q + 1'b1;
               if (aidx_q == AIW'(APP_WORDS - 1)) state_q <= ST_ADV;
            end
            ST_ADV: begin
               sof_q   <= eof_q;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_tready |-> (run && !halted && !idle));
   // R3
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RECV && cap_q != '0) |-> (cnt_q < cap_q));
   // R4
   used_desc_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_set |=> (halted && !s_tready));
   // R7
   done_then_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> (mem_wr && !mem_rd));
endmodule

// File: tb/sg_s2mm_rx_bench.sv
module sg_s2mm_rx_bench;
   localparam int AW = 16;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0, cur_we = 1'b0, tail_we = 1'b0;
   logic [AW-1:0] cur_wdata = '0, tail_wdata = '0, cur_ptr;
   logic halted, idle;
   logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
   logic [DW-1:0] s_tdata = '0;
   logic c_tvalid = 1'b0, c_tlast = 1'b0, c_tready;
   logic [DW-1:0] c_tdata = '0;
   logic mem_rd, mem_wr, pkt_done, ctl_err;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   logic [31:0] mem [0:1023];
   logic [31:0] pl  [0:63];
   int checks = 0, errors = 0, n_done = 0, n_err = 0;
   int unsigned seed = 32'd1357;

   always #2 clk = ~clk;

   sg_s2mm_rx u_sg_s2mm_rx (.*);

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:0]];
      if (rst_n && pkt_done) n_done <= n_done + 1;
      if (rst_n && ctl_err) n_err <= n_err + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_sts(input bit sof, input bit eof, input int len);
      return {1'b1, 3'b000, sof, eof, 3'b000, 23'(len)};
   endfunction

   task automatic set_desc(input int k, input int cap, input logic [31:0] sts);
      int b = 16 * k;
      mem[b] = 32'(16 * (k + 1));
      mem[b+1] = 32'(256 + 32 * k);
      mem[b+2] = 32'(cap);
      mem[b+3] = sts;
      for (int j = 0; j < 5; j++) mem[b+4+j] = 32'hA5A5_0000 + 32'(k * 8 + j);
   endtask

   task automatic send_ctl(input int n, input logic [31:0] base);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         c_tvalid = 1'b1; c_tdata = base + 32'(j); c_tlast = (j == n - 1);
      end
      @(negedge clk);
      c_tvalid = 1'b0; c_tlast = 1'b0;
   endtask

   task automatic send_pkt(input int n);
      for (int j = 0; j < n; j++) pl[j] = $urandom(seed + 32'(j)) ^ 32'(j);
      seed = seed + 32'd101;
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         s_tvalid = 1'b1; s_tdata = pl[j]; s_tlast = (j == n - 1);
         while (!s_tready) @(negedge clk);
      end
      @(negedge clk);
      s_tvalid = 1'b0; s_tlast = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   task automatic write_ptr(input bit tail, input int v);
      @(negedge clk);
      if (tail) begin tail_we = 1'b1; tail_wdata = AW'(v); end
      else begin cur_we = 1'b1; cur_wdata = AW'(v); end
      @(negedge clk);
      tail_we = 1'b0; cur_we = 1'b0;
   endtask

   task automatic chk_data(input string req, input int k, input int from, input int n);
      for (int j = 0; j < n; j++) check(req, mem[256 + 32 * k + j], pl[from + j]);
   endtask

   task automatic chk_app(input string req, input int k, input logic [31:0] base);
      for (int j = 0; j < 5; j++) check(req, mem[16 * k + 4 + j], base + 32'(j));
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 halted", 32'(halted), 1);
      check("R1 idle", 32'(idle), 0);
      check("R1 tready", 32'(s_tready), 0);
      check("R1 done", 32'(pkt_done), 0);
      check("R1 cur_ptr", 32'(cur_ptr), 0);

      set_desc(0, 4, 0); set_desc(1, 4, 0); set_desc(2, 8, 0);
      set_desc(3, 3, 0); set_desc(4, 3, 32'h8000_0000); set_desc(5, 4, 0);
      write_ptr(0, 0); write_ptr(1, 48);
      repeat (3) @(negedge clk);
      check("R2 ready low while stopped", 32'(s_tready), 0);
      @(negedge clk) run = 1'b1;
      repeat (2) @(negedge clk);
      check("R2 halted cleared by run", 32'(halted), 0);

      // packet spanning two descriptors
      send_ctl(5, 32'hC0DE_0000);
      send_pkt(6);
      chk_data("R3 first buffer", 0, 0, 4);
      chk_data("R3 spill buffer", 1, 4, 2);
      check("R6 sof-only status", mem[3], exp_sts(1, 0, 4));
      check("R5 eof status count", mem[19], exp_sts(0, 1, 2));
      chk_app("R7 non-eof app untouched", 0, 32'hA5A5_0000);
      chk_app("R7 eof app words", 1, 32'hC0DE_0000);
      check("R7 done pulses", 32'(n_done), 1);

      // single-descriptor packet
      send_ctl(5, 32'hB0B0_0000);
      send_pkt(3);
      chk_data("R3 short packet", 2, 0, 3);
      check("R6 sof after eof", mem[35], exp_sts(1, 1, 3));
      chk_app("R7 app second", 2, 32'hB0B0_0000);

      // exact fill of tail descriptor, no new control words
      send_pkt(3);
      chk_data("R3 exact fill", 3, 0, 3);
      check("R5 exact fill status", mem[51], exp_sts(1, 1, 3));
      chk_app("R10 old app reused", 3, 32'hB0B0_0000);
      check("R8 idle at tail", 32'(idle), 1);
      check("R8 cur advanced", 32'(cur_ptr), 64);
      check("R2 ready low when idle", 32'(s_tready), 0);

      // used descriptor halts
      write_ptr(1, 80);
      repeat (20) @(negedge clk);
      check("R4 halted", 32'(halted), 1);
      check("R4 ready low", 32'(s_tready), 0);
      check("R4 status untouched", mem[67], 32'h8000_0000);
      check("R4 buffer untouched", mem[256 + 128], 0);
      check("R4 cur held", 32'(cur_ptr), 64);

      // malformed control packets
      send_ctl(3, 32'hEEEE_0000);
      send_ctl(6, 32'hDDDD_0000);
      repeat (2) @(negedge clk);
      check("R9 error pulses", 32'(n_err), 2);

      // restart, packet spanning two more descriptors
      mem[67] = '0;
      @(negedge clk) run = 1'b0;
      @(negedge clk) run = 1'b1;
      send_pkt(5);
      chk_data("R3 restart first", 4, 0, 3);
      chk_data("R3 restart spill", 5, 3, 2);
      check("R6 sof restart", mem[67], exp_sts(1, 0, 3));
      check("R6 no sof mid packet", mem[83], exp_sts(0, 1, 2));
      chk_app("R9 bad words not latched", 5, 32'hB0B0_0000);
      check("R8 idle at new tail", 32'(idle), 1);
      check("R8 cur after restart", 32'(cur_ptr), 96);
      check("R7 done count", 32'(n_done), 4);

      // random packets, one descriptor each
      begin
         int caps [4];
         for (int k = 0; k < 4; k++) begin
            caps[k] = 1 + int'($urandom(seed + 32'(k)) % 6);
            set_desc(6 + k, caps[k], 0);
         end
         write_ptr(1, 144);
         for (int k = 0; k < 4; k++) begin
            int len = 1 + int'($urandom(seed + 32'd77 + 32'(k)) % caps[k]);
            logic [31:0] ab = 32'h1000_0000 * 32'(k + 1);
            send_ctl(5, ab);
            send_pkt(len);
            chk_data("R3 random data", 6 + k, 0, len);
            check("R5 random status", mem[16 * (6 + k) + 3], exp_sts(1, 1, len));
            chk_app("R7 random app", 6 + k, ab);
         end
         check("R8 idle after random", 32'(idle), 1);
         check("R8 cur after random", 32'(cur_ptr), 160);
      end
      finish_run();
   end
endmodule